// File: doc/BRIEF.md
# Embedded Erase Sequencer

This block runs a complete erase on a byte-wide memory array after a single request, with no further help from the host. The request either selects the whole array or names a set of sectors through a mask. For every selected byte, the sequencer first writes 0x00 and reads the byte back to confirm the write. A byte that does not read back as zero is written again, up to a fixed number of retries. Once every selected byte has been cleared and confirmed, the sequencer makes a second pass and writes 0xFF to each selected byte. Sectors that are not selected are never written.

The array itself sits outside the block. The block reaches it through a plain write port and a read port with zero latency. While an erase is running, the host reads a status byte through a polling port. The top bit of that byte is 0 while the erase is in progress and 1 once the block is idle again. Another bit flips on every status read that hits a sector being erased. A third bit reports that the retry limit was exceeded. The host can pause the erase with a suspend strobe and continue it with a resume strobe. Any other command strobe during an erase stops the run at once and leaves the array partly processed.

The request interface follows valid/ready rules. `req_ready` is high only while the block is idle. A request held on `req_valid` while `req_ready` is low is back-pressured: the host must keep it stable and it is not taken. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The other pins are plain level or strobe signals.

Top module: `erase_seq`

## Requirements
- R1: `req_ready` is 1 exactly when the block is idle. A request is taken on an edge where `req_valid` and `req_ready` are both 1, and `busy` reads 1 from the next cycle. Sector selection works as follows:
  - With `req_chip` = 1, every sector is selected.
  - Otherwise bit i of `req_mask` selects sector i.
  - The sector number is the address divided by SECT_BYTES.
- R2: In a first pass, every selected byte is written with 0x00 and read back on `mem_rdata` in the following cycle. No 0x00 write happens after the first 0xFF write of a run. With a healthy array, each selected byte gets exactly one 0x00 write.
- R3: A byte in a sector that is not selected is never written, and its contents are unchanged after the run.
- R4: In a second pass, every selected byte is written with 0xFF exactly once, in ascending address order. After that pass `busy` returns to 0 without further stimulus.
- R5: While `busy` is 1, bit 7 of `poll_data` is 0. While idle, `poll_data` is 0x80.
- R6: Bit 6 of `poll_data` inverts after each cycle in which `poll_rd` and `poll_hit` are both 1 and `suspended` is 0. In any other cycle it holds its value.
- R7: `poll_hit` is 1 exactly when `busy` is 1 and `poll_addr` lies in a selected sector.
- R8: A `suspend` strobe during a run has these effects:
  - The sequencer stops at the next byte boundary and `suspended` reads 1.
  - While suspended there are no memory writes and `mem_addr` holds still.
  - After a `resume` strobe the run continues from the held byte and ends with the same array contents as an uninterrupted run.
- R9: If a byte does not verify as 0x00, it is written with 0x00 again, for at most RETRY_MAX extra writes. After the last retry also fails:
  - Bit 5 of `poll_data` becomes 1 and bit 7 stays 0.
  - `busy` stays 1.
  - No further memory writes occur.
- R10: A `cmd_other` strobe while `busy` is 1 makes `busy` 0 in the next cycle and stops all writes. Bytes already written keep their new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Block idle; request can be taken |
| req_chip | input | 1 | Request targets every sector |
| req_mask | input | NUM_SECT | Per-sector selection when `req_chip` is 0 |
| suspend | input | 1 | Pause strobe |
| resume | input | 1 | Continue strobe |
| cmd_other | input | 1 | Any other command; stops a run |
| poll_rd | input | 1 | Status read strobe |
| poll_addr | input | ADDR_W | Address of the status read |
| poll_data | output | 8 | Status byte |
| poll_hit | output | 1 | Status read falls inside a selected sector |
| busy | output | 1 | Run in progress or failed |
| suspended | output | 1 | Paused at a byte boundary |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array address for write and read-back |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, same cycle |

## Verification
A corrupted address walker shows up on `mem_addr` at the next write. It appears either as a write into a sector that was not selected, or as a repeated or out-of-order 0xFF address, within a few cycles of the fault. A retry counter or phase register in the wrong state is visible in the number of 0x00 writes per byte. It also shows as a 0x00 write after the erase pass has begun, or as bit 5 of the status rising too early or never. A stale toggle or a missing pause decision is exposed on the very next status read, or as a write or address change during a cycle in which `suspended` is high.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PGM,
    ST_VFY,
    ST_ERS,
    ST_FAIL
  } seq_st_t;

  localparam logic [7:0] PGM_VAL = 8'h00;
  localparam logic [7:0] ERS_VAL = 8'hFF;
endpackage

// File: rtl/erase_seq_walker.sv
module erase_seq_walker #(
  parameter int NUM_SECT   = 4,
  parameter int SECT_BYTES = 4,
  localparam int SECT_W    = $clog2(SECT_BYTES),
  localparam int SEL_W     = $clog2(NUM_SECT),
  localparam int ADDR_W    = SEL_W + SECT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                step,
  input  logic [NUM_SECT-1:0] tgt_mask,
  output logic [ADDR_W-1:0]   addr,
  output logic                last,
  output logic                hit
);
  localparam int DEPTH = NUM_SECT * SECT_BYTES;

  always_ff @(posedge clk) begin
    if (!rst_n)     addr <= '0;
    else if (clr)   addr <= '0;
    else if (step)  addr <= addr + 1'b1;
  end

  assign last = (addr == ADDR_W'(DEPTH - 1));
  assign hit  = tgt_mask[addr[ADDR_W-1:SECT_W]];

  // The walker must never be asked to move past the final address.
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |-> !last);
endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
#(
  parameter int NUM_SECT  = 4,
  parameter int SEL_W     = 2,
  parameter int PGM_CYC   = 3,
  parameter int ERS_CYC   = 2,
  parameter int RETRY_MAX = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_chip,
  input  logic [NUM_SECT-1:0] req_mask,
  input  logic                suspend,
  input  logic                resume,
  input  logic                cmd_other,
  input  logic                hit,
  input  logic                last,
  input  logic [SEL_W-1:0]    wr_sect,
  input  logic [7:0]          mem_rdata,
  output logic                req_ready,
  output logic                walk_clr,
  output logic                walk_step,
  output logic                mem_we,
  output logic [7:0]          mem_wdata,
  output logic                busy,
  output logic                fail,
  output logic                pause,
  output logic [NUM_SECT-1:0] tgt_mask
);
  localparam int CMAX  = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
  localparam int CNT_W = (CMAX > 1) ? $clog2(CMAX) : 1;
  localparam int RTY_W = $clog2(RETRY_MAX + 1);

  seq_st_t           st;
  logic [CNT_W-1:0]  cnt, lim;
  logic [RTY_W-1:0]  retry;
  logic              susp, working, fire, skip, vfy_ok, advance, accept;

  assign working  = (st == ST_PGM) || (st == ST_ERS);
  assign lim      = (st == ST_ERS) ? CNT_W'(ERS_CYC - 1) : CNT_W'(PGM_CYC - 1);
  assign pause    = working && (cnt == '0) && susp;
  assign fire     = working && hit && !pause && (cnt == lim);
  assign skip     = working && !hit && !pause;
  assign vfy_ok   = (st == ST_VFY) && (mem_rdata == PGM_VAL);
  assign advance  = vfy_ok || ((st == ST_ERS) && fire) || skip;
  assign accept   = (st == ST_IDLE) && req_valid;

  assign walk_clr  = accept || (advance && last);
  assign walk_step = advance && !last;
  assign mem_we    = fire;
  assign mem_wdata = (st == ST_ERS) ? ERS_VAL : PGM_VAL;
  assign busy      = (st != ST_IDLE);
  assign fail      = (st == ST_FAIL);
  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; retry <= '0; susp <= 1'b0; tgt_mask <= '0;
    end else if (cmd_other && busy) begin
      st <= ST_IDLE; cnt <= '0; retry <= '0; susp <= 1'b0;
    end else begin
      if (st == ST_IDLE)  susp <= 1'b0;
      else if (suspend)   susp <= 1'b1;
      else if (resume)    susp <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          tgt_mask <= req_chip ? '1 : req_mask;
          st <= ST_PGM; cnt <= '0; retry <= '0;
        end
        ST_PGM: if (!pause) begin
          if (!hit) begin
            if (last) st <= ST_ERS;
          end else if (cnt == lim) begin
            cnt <= '0; st <= ST_VFY;
          end else cnt <= cnt + 1'b1;
        end
        ST_VFY: begin
          if (mem_rdata == PGM_VAL) begin
            retry <= '0;
            st <= last ? ST_ERS : ST_PGM;
          end else if (retry == RTY_W'(RETRY_MAX)) begin
            st <= ST_FAIL;
          end else begin
            retry <= retry + 1'b1; st <= ST_PGM;
          end
        end
        ST_ERS: if (!pause) begin
          if (!hit) begin
            if (last) st <= ST_IDLE;
          end else if (cnt == lim) begin
            cnt <= '0;
            if (last) st <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_FAIL: st <= ST_FAIL;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_write_in_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> tgt_mask[wr_sect]);
  assert_clear_then_check_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_wdata == PGM_VAL && !cmd_other) |=> (st == ST_VFY));
  assert_hold_while_paused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && $past(pause)) |-> $stable(wr_sect) && !mem_we);
  assert_quiet_after_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !mem_we);
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_other) |=> !busy);
  always_ff @(posedge clk)
    if (rst_n) assert_retry_cap_R9: assert (retry <= RTY_W'(RETRY_MAX));
endmodule

// File: rtl/erase_seq_status.sv
module erase_seq_status #(
  parameter int NUM_SECT = 4,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic                fail,
  input  logic                pause,
  input  logic [NUM_SECT-1:0] tgt_mask,
  input  logic                poll_rd,
  input  logic [SEL_W-1:0]    poll_sect,
  output logic [7:0]          poll_data,
  output logic                poll_hit
);
  logic tog;

  assign poll_hit  = busy && tgt_mask[poll_sect];
  assign poll_data = busy ? {1'b0, tog, fail, 5'b0} : 8'h80;

  always_ff @(posedge clk) begin
    if (!rst_n)                            tog <= 1'b0;
    else if (poll_rd && poll_hit && !pause) tog <= ~tog;
  end

  assert_toggle_per_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(poll_rd && poll_hit && !pause))
      |-> (poll_data[6] != $past(poll_data[6])));
  assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> poll_data[7]);
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int NUM_SECT   = 4,
  parameter int SECT_BYTES = 4,
  parameter int PGM_CYC    = 3,
  parameter int ERS_CYC    = 2,
  parameter int RETRY_MAX  = 2,
  localparam int SECT_W    = $clog2(SECT_BYTES),
  localparam int SEL_W     = $clog2(NUM_SECT),
  localparam int ADDR_W    = SEL_W + SECT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_chip,
  input  logic [NUM_SECT-1:0] req_mask,
  input  logic                suspend,
  input  logic                resume,
  input  logic                cmd_other,
  input  logic                poll_rd,
  input  logic [ADDR_W-1:0]   poll_addr,
  output logic [7:0]          poll_data,
  output logic                poll_hit,
  output logic                busy,
  output logic                suspended,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [7:0]          mem_wdata,
  input  logic [7:0]          mem_rdata
);
  logic                walk_clr, walk_step, last, hit, fail, pause;
  logic [NUM_SECT-1:0] tgt_mask;

  erase_seq_walker #(.NUM_SECT(NUM_SECT), .SECT_BYTES(SECT_BYTES)) u_walker (
    .clk(clk), .rst_n(rst_n), .clr(walk_clr), .step(walk_step),
    .tgt_mask(tgt_mask), .addr(mem_addr), .last(last), .hit(hit)
  );

  erase_seq_ctrl #(
    .NUM_SECT(NUM_SECT), .SEL_W(SEL_W), .PGM_CYC(PGM_CYC),
    .ERS_CYC(ERS_CYC), .RETRY_MAX(RETRY_MAX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chip(req_chip),
    .req_mask(req_mask), .suspend(suspend), .resume(resume),
    .cmd_other(cmd_other), .hit(hit), .last(last),
    .wr_sect(mem_addr[ADDR_W-1:SECT_W]), .mem_rdata(mem_rdata),
    .req_ready(req_ready), .walk_clr(walk_clr), .walk_step(walk_step),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .busy(busy), .fail(fail),
    .pause(pause), .tgt_mask(tgt_mask)
  );

  erase_seq_status #(.NUM_SECT(NUM_SECT), .SEL_W(SEL_W)) u_status (
    .clk(clk), .rst_n(rst_n), .busy(busy), .fail(fail), .pause(pause),
    .tgt_mask(tgt_mask), .poll_rd(poll_rd),
    .poll_sect(poll_addr[ADDR_W-1:SECT_W]),
    .poll_data(poll_data), .poll_hit(poll_hit)
  );

  assign suspended = pause;
endmodule

// File: tb/erase_seq_bench.sv
module erase_seq_bench;
  localparam int CLK_P = 10;
  localparam int NS    = 4;
  localparam int SB    = 4;
  localparam int DEPTH = NS * SB;
  localparam int AW    = 4;
  localparam int RMAX  = 2;

  logic clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_chip;
  logic [NS-1:0] req_mask;
  logic          suspend, resume, cmd_other, poll_rd;
  logic [AW-1:0] poll_addr;
  logic [7:0]    poll_data;
  logic          poll_hit, busy, suspended, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  erase_seq #(.NUM_SECT(NS), .SECT_BYTES(SB), .PGM_CYC(3), .ERS_CYC(2),
              .RETRY_MAX(RMAX)) u_erase_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chip(req_chip), .req_mask(req_mask), .suspend(suspend),
    .resume(resume), .cmd_other(cmd_other), .poll_rd(poll_rd),
    .poll_addr(poll_addr), .poll_data(poll_data), .poll_hit(poll_hit),
    .busy(busy), .suspended(suspended), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Array model with an optional stuck-at-one bit 0
  logic [7:0]    mem [DEPTH];
  logic          stuck_en;
  logic [AW-1:0] stuck_a;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk)
    if (mem_we)
      mem[mem_addr] <= (stuck_en && mem_addr == stuck_a) ? (mem_wdata | 8'h01) : mem_wdata;

  // Write recorder, sampled away from the active edge
  int wr0 [DEPTH];
  int wrf [DEPTH];
  int wr_total, last_f;
  bit any_f, order_bad, out_bad, asc_bad;
  logic [NS-1:0] tgt_b;
  always @(negedge clk)
    if (rst_n && mem_we) begin
      wr_total++;
      if (!tgt_b[int'(mem_addr) / SB]) out_bad = 1'b1;
      if (mem_wdata == 8'h00) begin
        wr0[mem_addr]++;
        if (any_f) order_bad = 1'b1;
      end else begin
        wrf[mem_addr]++;
        if (any_f && int'(mem_addr) <= last_f) asc_bad = 1'b1;
        any_f = 1'b1;
        last_f = int'(mem_addr);
      end
    end

  int n_chk = 0, n_fail = 0;
  bit ended = 1'b0;

  function automatic logic [7:0] pat(int i);
    return 8'(8'h41 + i * 5);
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic init_mem();
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = pat(i); wr0[i] = 0; wrf[i] = 0;
    end
    wr_total = 0; last_f = -1; any_f = 0; order_bad = 0; out_bad = 0; asc_bad = 0;
  endtask

  task automatic start(bit chip, logic [NS-1:0] mask);
    tick();
    check(req_ready == 1'b1, "R1 ready while idle", req_ready, 1);
    tgt_b = chip ? '1 : mask;
    req_valid = 1'b1; req_chip = chip; req_mask = mask;
    tick();
    req_valid = 1'b0; req_chip = 1'b0;
    check(busy == 1'b1, "R1 busy after accept", busy, 1);
    check(req_ready == 1'b0, "R1 back-pressure while busy", req_ready, 0);
  endtask

  task automatic run_poll();
    int  ta = 0;
    bit  have = 1'b0, prev_valid = 1'b0, prev_flip = 1'b0, prev_tog = 1'b0;
    int  guard = 0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (tgt_b[i / SB]) begin ta = i; have = 1'b1; end
    poll_addr = AW'(ta); poll_rd = have;
    while (busy && guard < 3000) begin
      #1;
      check(poll_hit == have, "R7 poll_hit in selected sector", poll_hit, have);
      check(poll_data[7] == 1'b0, "R5 bit7 low while busy", poll_data[7], 0);
      if (prev_valid && prev_flip)
        check(poll_data[6] != prev_tog, "R6 toggle after read", poll_data[6], !prev_tog);
      else if (prev_valid)
        check(poll_data[6] == prev_tog, "R6 hold without read", poll_data[6], prev_tog);
      prev_tog = poll_data[6]; prev_valid = 1'b1; prev_flip = have && !suspended;
      tick();
      guard++;
    end
    poll_rd = 1'b0;
    check(guard < 3000, "R4 run ends by itself", guard, 0);
    #1;
    check(poll_data == 8'h80, "R5 idle status", poll_data, 8'h80);
  endtask

  task automatic final_check(string tag);
    for (int i = 0; i < DEPTH; i++) begin
      if (tgt_b[i / SB]) begin
        check(mem[i] == 8'hFF, {"R4 erased byte ", tag}, mem[i], 8'hFF);
        check(wr0[i] == 1, {"R2 one clear write ", tag}, wr0[i], 1);
        check(wrf[i] == 1, {"R4 one erase write ", tag}, wrf[i], 1);
      end else begin
        check(mem[i] == pat(i), {"R3 unselected unchanged ", tag}, mem[i], pat(i));
        check(wr0[i] + wrf[i] == 0, {"R3 unselected unwritten ", tag}, wr0[i] + wrf[i], 0);
      end
    end
    check(!order_bad, {"R2 clear pass before erase pass ", tag}, order_bad, 0);
    check(!asc_bad, {"R4 ascending erase order ", tag}, asc_bad, 0);
    check(!out_bad, {"R3 no write outside target ", tag}, out_bad, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_fail++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_chip = 1'b0; req_mask = '0;
    suspend = 1'b0; resume = 1'b0; cmd_other = 1'b0; poll_rd = 1'b0;
    poll_addr = '0; stuck_en = 1'b0; stuck_a = '0; tgt_b = '0;
    init_mem();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    check(busy == 1'b0, "R1 reset idle", busy, 0);
    check(mem_we == 1'b0, "R3 reset no write", mem_we, 0);
    check(suspended == 1'b0, "R8 reset not suspended", suspended, 0);
    check(poll_data == 8'h80, "R5 reset status", poll_data, 8'h80);

    // Sweep every sector mask, then a whole-array request
    for (int m = 0; m < (1 << NS); m++) begin
      init_mem();
      start(1'b0, NS'(m));
      run_poll();
      final_check($sformatf("mask=%0h", m));
    end
    init_mem();
    start(1'b1, '0);
    run_poll();
    final_check("chip");

    // Suspend and resume in the middle of a run
    begin
      logic [AW-1:0] held;
      int w, g;
      bit t0;
      init_mem();
      start(1'b0, 4'b1011);
      repeat (9) tick();
      suspend = 1'b1; poll_rd = 1'b1; poll_addr = '0;
      tick();
      suspend = 1'b0;
      g = 0;
      while (!suspended && g < 50) begin tick(); g++; end
      check(suspended == 1'b1, "R8 reaches byte boundary", suspended, 1);
      held = mem_addr; w = wr_total; t0 = poll_data[6];
      for (int k = 0; k < 6; k++) begin
        tick();
        check(suspended == 1'b1, "R8 stays suspended", suspended, 1);
        check(mem_addr == held, "R8 address held", mem_addr, held);
        check(poll_data[6] == t0, "R6 no toggle while suspended", poll_data[6], t0);
      end
      check(wr_total == w, "R8 no writes while suspended", wr_total, w);
      poll_rd = 1'b0;
      resume = 1'b1;
      tick();
      resume = 1'b0;
      run_poll();
      final_check("suspend");
    end

    // Stuck bit: retries exhausted, failure flag, then abort
    begin
      int g, w, fsum;
      init_mem();
      stuck_en = 1'b1; stuck_a = AW'(5);
      start(1'b0, 4'b0010);
      poll_rd = 1'b1; poll_addr = AW'(4);
      g = 0;
      while (!(busy && poll_data[5]) && g < 500) begin tick(); g++; end
      check(poll_data[5] == 1'b1, "R9 fail bit set", poll_data[5], 1);
      check(poll_data[7] == 1'b0, "R9 bit7 stays low", poll_data[7], 0);
      check(busy == 1'b1, "R9 stays busy", busy, 1);
      check(wr0[5] == 1 + RMAX, "R9 clear writes on bad byte", wr0[5], 1 + RMAX);
      check(wr0[4] == 1, "R2 good byte cleared once", wr0[4], 1);
      check(wr0[6] == 0, "R9 later byte untouched", wr0[6], 0);
      fsum = 0;
      for (int i = 0; i < DEPTH; i++) fsum += wrf[i];
      check(fsum == 0, "R9 no erase writes", fsum, 0);
      w = wr_total;
      repeat (5) tick();
      check(wr_total == w, "R9 quiet after fail", wr_total, w);
      poll_rd = 1'b0;
      cmd_other = 1'b1;
      tick();
      cmd_other = 1'b0;
      check(busy == 1'b0, "R10 abort from failed state", busy, 0);
      check(req_ready == 1'b1, "R10 ready after abort", req_ready, 1);
      stuck_en = 1'b0;
    end

    // Abort during the clear pass
    begin
      int w;
      init_mem();
      start(1'b0, 4'b1111);
      repeat (6) tick();
      cmd_other = 1'b1;
      tick();
      cmd_other = 1'b0;
      check(busy == 1'b0, "R10 idle next cycle", busy, 0);
      w = wr_total;
      repeat (10) tick();
      check(wr_total == w, "R10 no writes after abort", wr_total, w);
      check(mem[0] == 8'h00, "R10 partial clear kept", mem[0], 8'h00);
      check(mem[DEPTH-1] == pat(DEPTH - 1), "R10 late byte untouched", mem[DEPTH-1], pat(DEPTH - 1));
    end

    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule